// File: doc/BRIEF.md
# Programmable Logic Cell with Lookup Table

This block is a single run-time programmable logic cell. It holds a small truth-table memory of eight rows by two bits. The three select inputs address that memory, so each of the two output bits can be any combinational function of the same three inputs. Each of the two output bits also has its own D flip-flop on the cell clock. A per-output mode bit chooses whether the cell output is the stored flip-flop value or the raw table value.

The truth table and both mode bits are loaded through one serial shift chain while the load-enable input is high. While a load is in progress, the cell drives zeros on its outputs and its flip-flops keep their state. The last stage of the chain is brought out so that several cells can be chained into one longer load path. The synchronous reset clears the two flip-flops and leaves the loaded configuration unchanged.

Top module: `logic_cell`

## Requirements
- R1: With an output's mode bit at 0 and `cfg_en` low, `cell_out[d]` equals bit d of table row `sel_in` in the same cycle. The row index is `{sel_in[2], sel_in[1], sel_in[0]}`, with bit 2 as the most significant bit.
- R2: The two output bits come from independent table columns, so they can implement two unrelated functions of the same three inputs.
- R3: With an output's mode bit at 1, `cell_out[d]` shows the table bit that was addressed at the previous rising edge, one cycle after the input changes.
- R4: The configuration word is 18 bits, shifted in most significant bit first. It starts with row 0 bit 1, then row 0 bit 0, then row 1 bit 1, and so on through row 7 bit 0. After the table come the mode bit of output 1 and then the mode bit of output 0. A mode bit of 1 selects the flip-flop.
- R5: The chain shifts only on rising edges where `cfg_en` is high. With `cfg_en` low, activity on `cfg_in` changes neither the cell function nor `cfg_out`.
- R6: While `cfg_en` is high, `cell_out` is 0, and the flip-flops hold the value they had before the load began.
- R7: A low `rst_n` clears both flip-flops at the next rising edge. The configuration is kept, so table-mode outputs continue to follow the loaded function during and after reset.
- R8: `cfg_out` is the oldest bit in the chain. After the k-th enabled shift (k from 0 to 17) it shows bit 17−k of the previously loaded word. After a full 18-bit load it shows the first bit that was shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rst_n | input | 1 | Synchronous active-low reset of the two output flip-flops |
| cfg_en | input | 1 | High to shift the configuration chain |
| cfg_in | input | 1 | Serial configuration data in |
| cfg_out | output | 1 | Last stage of the configuration chain |
| sel_in | input | 3 | Table address inputs, bit 2 most significant |
| cell_out | output | 2 | Cell outputs, each from the table or from its flip-flop |

## Verification
Results fall into three timing classes:
- **Table-mode outputs** depend on `sel_in` combinationally, so they are checked 1 ns after the input is changed on a falling edge.
- **Flip-flop-mode outputs** take one rising edge, so they are checked at the following falling edge. Just before that edge, the bench also checks that the previous value is still shown.
- **Configuration loads** take 18 enabled rising edges. At each falling edge during a load, the bench compares `cfg_out` with the bit of the previous word that should have reached the end of the chain. Zeroed outputs are checked at the same points.

After a load ends, the first check falls before any new capture, which shows that the flip-flop state was held.

// File: rtl/logic_cell_pkg.sv
// Shared types and sizing helpers for the programmable logic cell.
// Assumes the table has 2**addr_w rows, each out_w bits wide.
package logic_cell_pkg;

    // Source of each cell output
    typedef enum logic {
        SRC_LUT = 1'b0,
        SRC_FF  = 1'b1
    } out_src_e;

    // Total configuration bits: table contents plus one mode bit per output
    function automatic int cfg_width(input int addr_w, input int out_w);
        return (1 << addr_w) * out_w + out_w;
    endfunction

endpackage

// File: rtl/cfg_chain.sv
// Serial configuration shift register; its parallel contents are the cell's
// configuration memory. Shifts toward the MSB, so the first bit loaded
// ends up in bit WIDTH-1. Assumes WIDTH >= 2. Not reset by design.
module cfg_chain #(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             shift_en,
    input  logic             ser_in,
    output logic             ser_out,
    output logic [WIDTH-1:0] word
);

    // Shift one bit in per enabled edge, otherwise hold
    always_ff @(posedge clk) begin
        if (shift_en) begin
            word <= {word[WIDTH-2:0], ser_in};
        end
    end

    // Oldest bit leaves the chain for the next cell
    assign ser_out = word[WIDTH-1];

endmodule

// File: rtl/lut_read.sv
// Truth-table read port. Row e is stored with its highest data bit first,
// and row 0 occupies the most significant end of table_bits.
// Assumes the table bits are stable outside configuration loads.
module lut_read #(
    parameter int ADDR_W = 3,
    parameter int OUT_W  = 2
) (
    input  logic [(1<<ADDR_W)*OUT_W-1:0] table_bits,
    input  logic [ADDR_W-1:0]            addr,
    output logic [OUT_W-1:0]             data
);

    localparam int ENTRIES  = 1 << ADDR_W;
    localparam int LUT_BITS = ENTRIES * OUT_W;

    logic [OUT_W-1:0] rows [ENTRIES];

    // Slice the flat table into rows
    for (genvar e = 0; e < ENTRIES; e++) begin : g_row
        assign rows[e] = table_bits[LUT_BITS-1-e*OUT_W -: OUT_W];
    end

    // Select the addressed row
    assign data = rows[addr];

endmodule

// File: rtl/cell_out_bit.sv
// One output slice: a flip-flop capturing the table bit, and a 2:1 selection
// between flip-flop and raw table bit. During configuration (hold high)
// the flip-flop keeps its value and the output is forced low.
module cell_out_bit
    import logic_cell_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic lut_bit,
    input  logic use_reg,
    output logic q,
    output logic y
);

    // Capture the table bit unless a load is in progress
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (!hold) begin
            q <= lut_bit;
        end
    end

    // Choose the output source, blanked during a load
    always_comb begin
        if (hold) begin
            y = 1'b0;
        end else if (out_src_e'(use_reg) == SRC_FF) begin
            y = q;
        end else begin
            y = lut_bit;
        end
    end

endmodule

// File: rtl/logic_cell.sv
// Programmable logic cell: an addressable truth table with one optional
// flip-flop per output, configured through a single serial chain.
// Configuration word (MSB first): table rows 0..N-1 (highest data bit first),
// then mode bits from the highest output down to output 0.
module logic_cell
    import logic_cell_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int OUT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_in,
    output logic              cfg_out,
    input  logic [ADDR_W-1:0] sel_in,
    output logic [OUT_W-1:0]  cell_out
);

    localparam int CFG_W    = cfg_width(ADDR_W, OUT_W);
    localparam int LUT_BITS = CFG_W - OUT_W;

    logic [CFG_W-1:0]    cfg_word;
    logic [LUT_BITS-1:0] table_bits;
    logic [OUT_W-1:0]    mode_bits;
    logic [OUT_W-1:0]    lut_data;
    logic [OUT_W-1:0]    ff_q;

    // Configuration memory loaded serially
    cfg_chain #(
        .WIDTH(CFG_W)
    ) u_chain (
        .clk     (clk),
        .shift_en(cfg_en),
        .ser_in  (cfg_in),
        .ser_out (cfg_out),
        .word    (cfg_word)
    );

    // Split the word into table and mode fields
    assign table_bits = cfg_word[CFG_W-1:OUT_W];
    assign mode_bits  = cfg_word[OUT_W-1:0];

    // Table lookup
    lut_read #(
        .ADDR_W(ADDR_W),
        .OUT_W (OUT_W)
    ) u_lut (
        .table_bits(table_bits),
        .addr      (sel_in),
        .data      (lut_data)
    );

    // One register and output selection per output bit
    for (genvar d = 0; d < OUT_W; d++) begin : g_out
        cell_out_bit u_bit (
            .clk    (clk),
            .rst_n  (rst_n),
            .hold   (cfg_en),
            .lut_bit(lut_data[d]),
            .use_reg(mode_bits[d]),
            .q      (ff_q[d]),
            .y      (cell_out[d])
        );
    end

endmodule

// File: rtl/logic_cell_chk.sv
// Property checker for logic_cell, attached with bind. Observes the ports
// plus the table read data and flip-flop state driven by separate submodules.
module logic_cell_chk #(
    parameter int OUT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_en,
    input logic             cfg_out,
    input logic [OUT_W-1:0] cell_out,
    input logic [OUT_W-1:0] lut_data,
    input logic [OUT_W-1:0] ff_q
);

    // R6: outputs blanked during a load
    assert_blank_in_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |-> (cell_out == '0));

    // R6: flip-flops keep their state across a load cycle
    assert_ff_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> $stable(ff_q));

    // R3: outside a load the flip-flops take the previously addressed table bits
    assert_ff_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (ff_q == $past(lut_data)));

    // R7: reset clears the flip-flops at the next edge
    assert_reset_clears_R7: assert property (@(posedge clk)
        !rst_n |=> (ff_q == '0));

    // R5: chain end does not move without a shift enable
    assert_chain_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> $stable(cfg_out));

endmodule

bind logic_cell logic_cell_chk #(
    .OUT_W(OUT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_en  (cfg_en),
    .cfg_out (cfg_out),
    .cell_out(cell_out),
    .lut_data(lut_data),
    .ff_q    (ff_q)
);

// File: tb/logic_cell_tb.sv
// Directed bench for logic_cell: one task per scenario, each checking itself.
module logic_cell_tb;

    logic       clk    = 1'b0;
    logic       rst_n  = 1'b0;
    logic       cfg_en = 1'b0;
    logic       cfg_in = 1'b0;
    logic [2:0] sel_in = 3'd0;
    logic       cfg_out;
    logic [1:0] cell_out;

    int total = 0;
    int bad   = 0;
    logic [17:0] cur_word   = '0;
    bit          word_valid = 1'b0;

    logic_cell u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_en  (cfg_en),
        .cfg_in  (cfg_in),
        .cfg_out (cfg_out),
        .sel_in  (sel_in),
        .cell_out(cell_out)
    );

    // 125 MHz clock
    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Build a configuration word from two truth tables and the mode bits (R4)
    function automatic logic [17:0] mk(input logic [7:0] f1, input logic [7:0] f0,
                                       input logic [1:0] mode);
        logic [17:0] w;
        w = '0;
        for (int e = 0; e < 8; e++) begin
            w[17-2*e] = f1[e];
            w[16-2*e] = f0[e];
        end
        w[1:0] = mode;
        return w;
    endfunction

    function automatic logic [1:0] row_of(input logic [17:0] w, input int a);
        return {w[17-2*a], w[16-2*a]};
    endfunction

    // Serial load, checking blanking (R6) and chain end (R8) at every step
    task automatic load(input logic [17:0] w);
        for (int i = 17; i >= 0; i--) begin
            @(negedge clk);
            cfg_en = 1'b1;
            cfg_in = w[i];
            #1;
            chk("R6 outputs zero during load", cell_out, 2'b00);
            if (word_valid)
                chk("R8 chain end shows previous word", {1'b0, cfg_out},
                    {1'b0, cur_word[i]});
        end
        @(negedge clk);
        cfg_en   = 1'b0;
        cfg_in   = 1'b0;
        cur_word = w;
        word_valid = 1'b1;
        #1;
        chk("R8 chain end shows first loaded bit", {1'b0, cfg_out}, {1'b0, w[17]});
    endtask

    task automatic sweep_comb(input string req);
        for (int a = 0; a < 8; a++) begin
            @(negedge clk);
            sel_in = 3'(a);
            #1;
            chk(req, cell_out, row_of(cur_word, a));
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        load(mk(8'hFF, 8'hFF, 2'b11));
        @(negedge clk);
        #1;
        chk("R7 flip-flops cleared in reset", cell_out, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R3 first capture after reset", cell_out, 2'b11);
    endtask

    task automatic t_comb_funcs;
        // parity on bit 1, majority on bit 0
        load(mk(8'h96, 8'hE8, 2'b00));
        sweep_comb("R1 R2 parity and majority");
    endtask

    task automatic t_order;
        // single hot rows expose the row and bit order
        load(mk(8'h20, 8'h04, 2'b00));
        sweep_comb("R4 row and bit order");
    endtask

    task automatic t_registered;
        logic [1:0] prev;
        load(mk(8'h80, 8'hFE, 2'b11));
        @(negedge clk);
        sel_in = 3'd0;
        @(negedge clk);
        prev = row_of(cur_word, 0);
        for (int a = 1; a < 8; a++) begin
            sel_in = 3'(a);
            #1;
            chk("R3 value before edge", cell_out, prev);
            @(negedge clk);
            #1;
            chk("R3 registered after one edge", cell_out, row_of(cur_word, a));
            prev = row_of(cur_word, a);
        end
    endtask

    task automatic t_mixed;
        logic [1:0] prev;
        // out1 from flip-flop, out0 straight from table (R4 mode order)
        load(mk(8'h96, 8'h96, 2'b10));
        @(negedge clk);
        sel_in = 3'd0;
        @(negedge clk);
        prev = row_of(cur_word, 0);
        for (int a = 1; a < 8; a++) begin
            sel_in = 3'(a);
            #1;
            chk("R4 mode bits per output", cell_out, {prev[1], row_of(cur_word, a)[0]});
            @(negedge clk);
            prev = row_of(cur_word, a);
        end
    endtask

    task automatic t_hold;
        load(mk(8'hFF, 8'hFF, 2'b11));
        @(negedge clk);
        @(negedge clk);
        #1;
        chk("R6 ones captured before load", cell_out, 2'b11);
        load(mk(8'h00, 8'h00, 2'b11));
        chk("R6 flip-flops held across load", cell_out, 2'b11);
        @(negedge clk);
        #1;
        chk("R6 capture resumes after load", cell_out, 2'b00);
    endtask

    task automatic t_ignore;
        load(mk(8'h96, 8'hE8, 2'b00));
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            cfg_in = ~cfg_in;
        end
        #1;
        chk("R5 chain end unchanged without enable", {1'b0, cfg_out}, {1'b0, cur_word[17]});
        sweep_comb("R5 function unchanged without enable");
        cfg_in = 1'b0;
    endtask

    task automatic t_reset_keeps;
        @(negedge clk);
        rst_n = 1'b0;
        sweep_comb("R7 table outputs live in reset");
        rst_n = 1'b1;
        sweep_comb("R7 configuration kept after reset");
        load(mk(8'hFF, 8'hFF, 2'b11));
        @(negedge clk);
        @(negedge clk);
        #1;
        chk("R7 registered ones before reset", cell_out, 2'b11);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        chk("R7 registered cleared by reset", cell_out, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R7 registered recovers", cell_out, 2'b11);
    endtask

    initial begin
        #(8 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_comb_funcs();
        t_order();
        t_registered();
        t_mixed();
        t_hold();
        t_ignore();
        t_reset_keeps();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule